// File: doc/BRIEF.md
# Three-wire serial EEPROM slave model

This block stands in for a small three-wire serial EEPROM so that a master controller can be exercised against a device that answers like the real part. It sits on a select line, a serial clock, a serial data input and a serial data output. The serial lines are sampled in the host clock domain, so the serial clock must run well below the host clock. A rising serial clock edge seen while select is high moves one bit.

A frame opens with a single 1 bit, carries a two-bit opcode and then an address field whose width follows the array size and the word organisation. Reads stream words out for as long as clocks keep arriving. Writes carry one word. Special commands put their operation code in the top two address bits. Erase-all and word writes only take effect when a write-enable latch is set. Each accepted write or erase raises a busy flag for a fixed number of host cycles. While busy is high the block refuses new frames.

Two build options match device variants. One adds a dummy clock before read data appears. The other accepts two extra trailing bits on special commands.

Top module: `mw_eeprom_slave`

## Requirements
- R1: While select is high, 0 bits before the first 1 bit are ignored. That 1 bit starts a frame. The next two bits are the opcode: 10 means read, 01 means write, 00 means special.
- R2: The address follows the opcode, MSB first. Its width is log2(bytes) for 8-bit words and log2(bytes)-1 for 16-bit words. A 256-byte array of 16-bit words therefore uses 7 address bits.
- R3: On a read, the first data bit (the MSB) is on the output after the rising clock that samples the last address bit. Each later rising clock moves to the next bit. After the last bit of a word, the next word follows, and the address wraps from the top of the array back to 0.
- R4: With the dummy-bit option, the output holds 0 for one extra rising clock after the address, and only then does the word's MSB appear.
- R5: A write sends one data word, MSB first, right after the address: 8 bits for 8-bit words, 16 bits for 16-bit words. The word is stored when the frame completes with the latch set.
- R6: For a special command, the top two address bits select the operation: 11 sets the write-enable latch, 00 clears it, 10 sets every bit of the array to 1. The remaining address bits are don't-care.
- R7: The write-enable latch is clear after reset. Writes and erase-all have no effect while it is clear.
- R8: With the trailing-bit option, a special command executes only after two further bits follow the address. If select drops before those bits arrive, the command does nothing.
- R9: An accepted write or erase-all holds busy high for BUSY_CYCLES host cycles. A frame whose start bit arrives while busy is high is discarded until select falls.
- R10: Dropping select abandons any partial frame without effect. The data output is 0 in the cycle after select is seen low.
- R11: After reset, the data output and busy are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sel_i | input | 1 | Device select, active high |
| sclk_i | input | 1 | Serial clock; a rising edge moves one bit |
| sdi_i | input | 1 | Serial command, address and data input |
| sdo_o | output | 1 | Serial read data output |
| busy_o | output | 1 | High while a simulated program or erase cycle runs |

## Verification
The bench builds two instances on shared serial lines with separate selects, both with BUSY_CYCLES set to 300. The first is a 128-byte array of 8-bit words with neither option. It covers the table-driven write and readback, leading zeros, aborts, busy refusal and the latch gating. The second is a 256-byte array of 16-bit words with both the dummy read bit and the trailing special bits. It confirms that the address stays at 7 bits as the array doubles, that a 16-bit read crosses the wrap boundary, that the dummy clock reads as 0, and that a special command missing its tail has no effect.

// File: rtl/mw_slave_pkg.sv
package mw_slave_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_TAIL,
    ST_DUMMY,
    ST_READ,
    ST_HOLD
  } mw_state_e;

  localparam logic [1:0] OPC_READ    = 2'b10;
  localparam logic [1:0] OPC_WRITE   = 2'b01;
  localparam logic [1:0] OPC_SPECIAL = 2'b00;

  localparam logic [1:0] SP_ENABLE  = 2'b11;
  localparam logic [1:0] SP_ERASE   = 2'b10;
  localparam logic [1:0] SP_DISABLE = 2'b00;
endpackage

// File: rtl/mw_cmd_decoder.sv
module mw_cmd_decoder
  import mw_slave_pkg::*;
#(
  parameter int AW           = 7,
  parameter int WW           = 8,
  parameter int DUMMY_BIT    = 0,
  parameter int SPECIAL_TAIL = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_i,
  input  logic          sclk_i,
  input  logic          sdi_i,
  input  logic          busy_i,
  input  logic [WW-1:0] rd_word_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          sdo_o,
  output logic          wr_stb_o,
  output logic          en_stb_o,
  output logic          dis_stb_o,
  output logic          erase_stb_o,
  output logic [AW-1:0] cmd_addr_o,
  output logic [WW-1:0] cmd_data_o
);
  localparam int CW = $clog2(((AW > WW) ? AW : WW) + 1);
  localparam mw_state_e READ_ENTRY = (DUMMY_BIT != 0) ? ST_DUMMY : ST_READ;

  mw_state_e     state_q, state_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [1:0]    opc_q, opc_n;
  logic [AW-1:0] addr_q, addr_n, ptr_q, ptr_n;
  logic [WW-1:0] data_q, data_n, shifted;
  logic          sclk_q, rise, special_go;
  logic          wr_n, en_n, dis_n, er_n;

  assign rise = sclk_i & ~sclk_q & sel_i;

  always_comb begin
    state_n    = state_q;
    cnt_n      = cnt_q;
    opc_n      = opc_q;
    addr_n     = addr_q;
    data_n     = data_q;
    ptr_n      = ptr_q;
    wr_n       = 1'b0;
    en_n       = 1'b0;
    dis_n      = 1'b0;
    er_n       = 1'b0;
    special_go = 1'b0;
    if (!sel_i) begin
      state_n = ST_IDLE;
    end else if (rise) begin
      case (state_q)
        ST_IDLE: if (sdi_i) begin
          state_n = busy_i ? ST_HOLD : ST_OPC;
          cnt_n   = '0;
        end
        ST_OPC: begin
          opc_n = {opc_q[0], sdi_i};
          if (cnt_q == CW'(1)) begin
            state_n = ST_ADDR;
            cnt_n   = '0;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        ST_ADDR: begin
          addr_n = {addr_q[AW-2:0], sdi_i};
          if (cnt_q == CW'(AW-1)) begin
            cnt_n = '0;
            case (opc_q)
              OPC_READ: begin
                ptr_n   = {addr_q[AW-2:0], sdi_i};
                state_n = READ_ENTRY;
              end
              OPC_WRITE: state_n = ST_DATA;
              OPC_SPECIAL: begin
                if (SPECIAL_TAIL != 0) begin
                  state_n = ST_TAIL;
                end else begin
                  special_go = 1'b1;
                  state_n    = ST_HOLD;
                end
              end
              default: state_n = ST_HOLD;
            endcase
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          data_n = {data_q[WW-2:0], sdi_i};
          if (cnt_q == CW'(WW-1)) begin
            wr_n    = 1'b1;
            state_n = ST_HOLD;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        ST_TAIL: begin
          if (cnt_q == CW'(1)) begin
            special_go = 1'b1;
            state_n    = ST_HOLD;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        ST_DUMMY: begin
          state_n = ST_READ;
          cnt_n   = '0;
        end
        ST_READ: begin
          if (cnt_q == CW'(WW-1)) begin
            cnt_n = '0;
            ptr_n = ptr_q + 1'b1;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
    if (special_go) begin
      case (addr_n[AW-1 -: 2])
        SP_ENABLE:  en_n  = 1'b1;
        SP_ERASE:   er_n  = 1'b1;
        SP_DISABLE: dis_n = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q      <= 1'b0;
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      opc_q       <= '0;
      addr_q      <= '0;
      data_q      <= '0;
      ptr_q       <= '0;
      wr_stb_o    <= 1'b0;
      en_stb_o    <= 1'b0;
      dis_stb_o   <= 1'b0;
      erase_stb_o <= 1'b0;
    end else begin
      sclk_q      <= sclk_i;
      state_q     <= state_n;
      cnt_q       <= cnt_n;
      opc_q       <= opc_n;
      addr_q      <= addr_n;
      data_q      <= data_n;
      ptr_q       <= ptr_n;
      wr_stb_o    <= wr_n;
      en_stb_o    <= en_n;
      dis_stb_o   <= dis_n;
      erase_stb_o <= er_n;
    end
  end

  assign shifted    = rd_word_i << cnt_q;
  assign sdo_o      = (state_q == ST_READ) & shifted[WW-1];
  assign rd_addr_o  = ptr_q;
  assign cmd_addr_o = addr_q;
  assign cmd_data_o = data_q;
endmodule

// File: rtl/mw_word_store.sv
module mw_word_store #(
  parameter int AW = 7,
  parameter int WW = 8
) (
  input  logic          clk,
  input  logic          wr_en_i,
  input  logic          erase_i,
  input  logic [AW-1:0] addr_i,
  input  logic [WW-1:0] data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [WW-1:0] rd_word_o
);
  localparam int DEPTH = 1 << AW;

  logic [WW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (erase_i) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (wr_en_i) begin
      mem[addr_i] <= data_i;
    end
  end

  assign rd_word_o = mem[rd_addr_i];
endmodule

// File: rtl/mw_busy_timer.sv
module mw_busy_timer #(
  parameter int BUSY_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int TW = $clog2(BUSY_CYCLES + 1);

  logic [TW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (start_i)            cnt_n = TW'(BUSY_CYCLES);
    else if (cnt_q != '0)   cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave #(
  parameter int MEM_BYTES    = 128,
  parameter int WORD16       = 0,
  parameter int DUMMY_BIT    = 0,
  parameter int SPECIAL_TAIL = 0,
  parameter int BUSY_CYCLES  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_i,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic sdo_o,
  output logic busy_o
);
  localparam int WW = (WORD16 != 0) ? 16 : 8;
  localparam int AW = $clog2(MEM_BYTES) - ((WORD16 != 0) ? 1 : 0);

  logic [1:0]    rst_pipe;
  logic          rst_q;
  logic          wel_q, wel_n;
  logic          wr_stb, en_stb, dis_stb, erase_stb;
  logic          commit_wr, commit_er;
  logic [AW-1:0] rd_addr, cmd_addr;
  logic [WW-1:0] rd_word, cmd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  mw_cmd_decoder #(
    .AW(AW), .WW(WW), .DUMMY_BIT(DUMMY_BIT), .SPECIAL_TAIL(SPECIAL_TAIL)
  ) u_decoder (
    .clk(clk), .rst_n(rst_q), .sel_i(sel_i), .sclk_i(sclk_i), .sdi_i(sdi_i),
    .busy_i(busy_o), .rd_word_i(rd_word), .rd_addr_o(rd_addr), .sdo_o(sdo_o),
    .wr_stb_o(wr_stb), .en_stb_o(en_stb), .dis_stb_o(dis_stb),
    .erase_stb_o(erase_stb), .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data)
  );

  always_comb begin
    wel_n = wel_q;
    if (en_stb)       wel_n = 1'b1;
    else if (dis_stb) wel_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) wel_q <= 1'b0;
    else        wel_q <= wel_n;
  end

  assign commit_wr = wr_stb & wel_q;
  assign commit_er = erase_stb & wel_q;

  mw_word_store #(.AW(AW), .WW(WW)) u_store (
    .clk(clk), .wr_en_i(commit_wr), .erase_i(commit_er), .addr_i(cmd_addr),
    .data_i(cmd_data), .rd_addr_i(rd_addr), .rd_word_o(rd_word)
  );

  mw_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_q), .start_i(commit_wr | commit_er), .busy_o(busy_o)
  );
endmodule

// File: rtl/mw_eeprom_checker.sv
module mw_eeprom_checker #(
  parameter int BUSY_CYCLES = 64
) (
  input logic clk,
  input logic rst_n,
  input logic sel_i,
  input logic sdo_o,
  input logic busy_o,
  input logic wel_q,
  input logic wr_stb,
  input logic en_stb,
  input logic dis_stb,
  input logic erase_stb
);
  int unsigned run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= 0;
    else if (busy_o) run_q <= run_q + 1;
    else             run_q <= 0;
  end

  p_sdo_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_i |=> !sdo_o);

  p_enable_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en_stb |=> wel_q);

  p_disable_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dis_stb |=> !wel_q);

  p_busy_needs_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(wel_q));

  p_commit_starts_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_stb || erase_stb) && wel_q) |=> busy_o);

  p_no_commit_while_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !(wr_stb || erase_stb));

  p_busy_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= BUSY_CYCLES);
endmodule

bind mw_eeprom_slave mw_eeprom_checker #(.BUSY_CYCLES(BUSY_CYCLES)) u_checker (
  .clk(clk), .rst_n(rst_q), .sel_i(sel_i), .sdo_o(sdo_o), .busy_o(busy_o),
  .wel_q(wel_q), .wr_stb(wr_stb), .en_stb(en_stb), .dis_stb(dis_stb),
  .erase_stb(erase_stb)
);

// File: tb/mw_eeprom_slave_bench.sv
module mw_eeprom_slave_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_a = 1'b0, sel_b = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic sdo_a, sdo_b, busy_a, busy_b;
  int errors = 0, checks = 0;
  bit done = 1'b0;
  logic [63:0] cap;

  always #5 clk = ~clk;

  mw_eeprom_slave #(.MEM_BYTES(128), .WORD16(0), .DUMMY_BIT(0), .SPECIAL_TAIL(0),
                    .BUSY_CYCLES(300)) u_mw_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_a), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo_a), .busy_o(busy_a));

  mw_eeprom_slave #(.MEM_BYTES(256), .WORD16(1), .DUMMY_BIT(1), .SPECIAL_TAIL(1),
                    .BUSY_CYCLES(300)) u_mw_eeprom_slave_x16 (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_b), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo_b), .busy_o(busy_b));

  localparam logic [14:0] WR_TABLE [4] = '{
    {7'h00, 8'hA5}, {7'h7F, 8'h5A}, {7'h12, 8'h81}, {7'h40, 8'h0F}};

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic clock_bit(input bit dev, input logic b);
    @(negedge clk); sdi = b; sclk = 1'b1;
    repeat (3) @(negedge clk);
    cap = {cap[62:0], dev ? sdo_b : sdo_a};
    sclk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic end_frame();
    @(negedge clk); sel_a = 1'b0; sel_b = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic frame(input bit dev, input logic [63:0] bits, input int len,
                       input int extra, input bit close);
    @(negedge clk);
    if (dev) sel_b = 1'b1; else sel_a = 1'b1;
    cap = '0;
    for (int i = len - 1; i >= 0; i--) clock_bit(dev, bits[i]);
    for (int i = 0; i < extra; i++) clock_bit(dev, 1'b0);
    if (close) end_frame();
  endtask

  task automatic wait_idle();
    int t = 0;
    while ((busy_a || busy_b) && t < 5000) begin @(negedge clk); t++; end
  endtask

  task automatic spec_a(input logic [1:0] op);
    frame(1'b0, {1'b1, 2'b00, op, 5'b0}, 10, 0, 1'b1);
  endtask
  task automatic write_a(input logic [6:0] a, input logic [7:0] d);
    frame(1'b0, {1'b1, 2'b01, a, d}, 18, 0, 1'b1);
  endtask
  task automatic read_a(input logic [6:0] a, input int n);
    frame(1'b0, {1'b1, 2'b10, a}, 10, 8 * n - 1, 1'b1);
  endtask
  task automatic write_b(input logic [6:0] a, input logic [15:0] d);
    frame(1'b1, {1'b1, 2'b01, a, d}, 26, 0, 1'b1);
  endtask
  task automatic read_b(input logic [6:0] a, input int n);
    frame(1'b1, {1'b1, 2'b10, a}, 10, 16 * n, 1'b1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 sdo after reset", {31'b0, sdo_a | sdo_b}, 0);
    check("R11 busy after reset", {31'b0, busy_a | busy_b}, 0);

    // R6 erase-all, R7 latch gating
    spec_a(2'b11);
    spec_a(2'b10);
    check("R9 busy after erase", {31'b0, busy_a}, 1);
    wait_idle();
    spec_a(2'b00);
    write_a(7'h05, 8'h3C);
    check("R7 no busy when latch clear", {31'b0, busy_a}, 0);
    read_a(7'h05, 1);
    check("R6 R7 erased word kept", {24'b0, cap[7:0]}, 32'hFF);

    // R5 R3 table walk
    spec_a(2'b11);
    foreach (WR_TABLE[i]) begin
      write_a(WR_TABLE[i][14:8], WR_TABLE[i][7:0]);
      check("R9 busy after write", {31'b0, busy_a}, 1);
      wait_idle();
    end
    foreach (WR_TABLE[i]) begin
      read_a(WR_TABLE[i][14:8], 1);
      check("R5 readback", {24'b0, cap[7:0]}, {24'b0, WR_TABLE[i][7:0]});
    end

    // R3 sequential read across the top of the array
    read_a(7'h7F, 2);
    check("R3 wrap word0", {16'b0, cap[15:0]}, 32'h5AA5);

    // R1 leading zeros before the start bit
    frame(1'b0, {3'b000, 1'b1, 2'b10, 7'h12}, 13, 7, 1'b1);
    check("R1 leading zeros", {24'b0, cap[7:0]}, 32'h81);

    // R10 aborted write and aborted read
    frame(1'b0, {1'b1, 2'b01, 7'h12, 4'hF}, 14, 0, 1'b1);
    check("R10 abort no busy", {31'b0, busy_a}, 0);
    read_a(7'h12, 1);
    check("R10 abort no write", {24'b0, cap[7:0]}, 32'h81);
    frame(1'b0, {1'b1, 2'b10, 7'h00}, 10, 0, 1'b0);
    check("R3 first bit on last address edge", {31'b0, cap[0]}, 1);
    @(negedge clk); sel_a = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 sdo low after select drop", {31'b0, sdo_a}, 0);
    end_frame();

    // R9 refusal while busy and busy length
    write_a(7'h40, 8'h11);
    write_a(7'h12, 8'h22);
    wait_idle();
    read_a(7'h40, 1);
    check("R9 first write stored", {24'b0, cap[7:0]}, 32'h11);
    read_a(7'h12, 1);
    check("R9 write during busy ignored", {24'b0, cap[7:0]}, 32'h81);
    write_a(7'h41, 8'h77);
    begin
      int t = 0;
      while (busy_a && t < 1000) begin @(negedge clk); t++; end
      check("R9 busy length", {31'b0, (t >= 288 && t <= 296)}, 1);
    end

    // R7 disable blocks write and erase
    spec_a(2'b00);
    write_a(7'h00, 8'h00);
    spec_a(2'b10);
    check("R7 erase refused", {31'b0, busy_a}, 0);
    read_a(7'h7F, 2);
    check("R7 contents unchanged", {16'b0, cap[15:0]}, 32'h5AA5);

    // x16 instance: R2 R4 R5 R8
    frame(1'b1, {1'b1, 2'b00, 2'b11, 5'b0, 2'b00}, 12, 0, 1'b1);
    write_b(7'h7E, 16'hBEEF); wait_idle();
    write_b(7'h7F, 16'h1234); wait_idle();
    write_b(7'h00, 16'hCAFE); wait_idle();
    read_b(7'h7E, 3);
    check("R4 dummy bit reads 0", {31'b0, cap[48]}, 0);
    check("R2 R5 x16 word0", {16'b0, cap[47:32]}, 32'hBEEF);
    check("R3 x16 word1", {16'b0, cap[31:16]}, 32'h1234);
    check("R3 x16 wrap word2", {16'b0, cap[15:0]}, 32'hCAFE);
    frame(1'b1, {1'b1, 2'b00, 2'b00, 5'b0}, 10, 0, 1'b1);
    write_b(7'h05, 16'h0505); wait_idle();
    read_b(7'h05, 1);
    check("R8 special without tail ignored", {16'b0, cap[15:0]}, 32'h0505);
    frame(1'b1, {1'b1, 2'b00, 2'b10, 5'b0, 2'b00}, 12, 0, 1'b1);
    check("R8 erase with tail busy", {31'b0, busy_b}, 1);
    wait_idle();
    read_b(7'h00, 1);
    check("R6 x16 erased", {16'b0, cap[15:0]}, 32'hFFFF);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule